// File: doc/BRIEF.md
# Lane-Masked Single-Port Word Store

A synchronous single-port memory whose words are split into byte lanes that each carry eight data bits and one parity bit. Each clock edge samples an address, an active-low chip select and an active-low write enable. A write stores only the lanes picked by the active-low lane selects, so a partial update needs no read-modify-write cycle. A read registers the addressed word and presents it on the output one clock later.

The data path models a shared bidirectional bus as three signals: a write-data input, a read-data output and an output-drive enable. A wrapper or pad ring joins them into one tri-state bus. The drive enable follows the active-low output enable. It is also forced off during the data phase of every write, whatever the output enable says, so the store never drives the bus while the host does. The number of words is a parameter.

Top module: `lane_write_store`

## Requirements
- R1: A cycle with chip select low and write enable low writes `din` lane i (bits `[9i+8:9i]`) into the addressed word for each i where `lane_sel_n[i]` is low.
- R2: Lanes whose `lane_sel_n` bit is high during a write keep their previous contents.
- R3: A word is 36 bits made of four 9-bit lanes. Lane i sits at bits `[9i+8:9i]` and is controlled only by `lane_sel_n[i]`.
- R4: A cycle with chip select low and write enable high reads the addressed word. On the next cycle `dout` holds that word and `dout_en` is high, provided `oe_n` is low and no write is being presented.
- R5: While `oe_n` is high, `dout_en` is low in the same cycle.
- R6: While a write is presented (chip select low, write enable low), `dout_en` is low whatever `oe_n` is.
- R7: A cycle with chip select high writes nothing, whatever the write controls are, and `dout_en` is low on the following cycle.
- R8: A write with all four lane selects high leaves the addressed word unchanged, and `dout_en` stays low in that cycle.
- R9: While reset is asserted and right after its release, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| lane_sel_n | input | LANES | Active-low per-lane write selects |
| oe_n | input | 1 | Active-low output enable |
| din | input | LANES*LANE_W | Write data from the shared bus |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Drive enable for the shared bus |

## Verification
On every cycle the assertions check the drive enable against output enable, write presence, deselect and reset. They also check that the per-lane write strobes never fire for a deselected cycle or an unselected lane, and that a completed read with output enable low turns the drive on. Whether the right bits reach the right word, whether untouched lanes keep their old contents, and whether a read returns what an earlier masked write left can only be shown by the bench. It sweeps every address against all sixteen lane masks and compares each read against a model it builds itself.

// File: rtl/lws_pkg.sv
package lws_pkg;

  // Kind of access presented on the control pins in the current cycle.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;

  // Decode the active-low select and write enable into an access kind.
  function automatic cyc_kind_e classify(input logic sel_n, input logic wr_n);
    if (sel_n)     return CYC_IDLE;
    else if (wr_n) return CYC_READ;
    else           return CYC_WRITE;
  endfunction

endpackage

// File: rtl/lws_ctrl.sv
module lws_ctrl
  import lws_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             cs_n,
  input  logic             we_n,
  input  logic [LANES-1:0] lane_sel_n,
  output cyc_kind_e        cyc,
  output logic [LANES-1:0] wr_lane_en,
  output logic             rd_fire
);

  assign cyc     = classify(cs_n, we_n);
  assign rd_fire = (cyc == CYC_READ);

  // One strobe per lane; a write with no lane selected raises none.
  for (genvar g = 0; g < LANES; g++) begin : g_strobe
    assign wr_lane_en[g] = (cyc == CYC_WRITE) && !lane_sel_n[g];
  end

endmodule

// File: rtl/lws_array.sv
module lws_array #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        wr_lane_en,
  input  logic                    rd_fire,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  // Each lane is its own narrow storage column with its own write strobe.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] column [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_lane_en[g]) column[addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_fire)       rd_q         <= column[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/lws_outdrv.sv
module lws_outdrv
  import lws_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cyc_kind_e cyc,
  input  logic      rd_fire,
  input  logic      oe_n,
  output logic      rd_valid,
  output logic      dout_en
);

  // Set for the cycle after a read was sampled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_fire;
  end

  // A presented write owns the bus for its data phase.
  logic write_phase;
  assign write_phase = (cyc == CYC_WRITE);
  assign dout_en     = rd_valid && !oe_n && !write_phase;

endmodule

// File: rtl/lane_write_store.sv
module lane_write_store
  import lws_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  cyc_kind_e        cyc;
  logic [LANES-1:0] wr_lane_en;
  logic             rd_fire;
  logic             rd_valid;

  lws_ctrl #(.LANES(LANES)) u_ctrl (
    .cs_n       (cs_n),
    .we_n       (we_n),
    .lane_sel_n (lane_sel_n),
    .cyc        (cyc),
    .wr_lane_en (wr_lane_en),
    .rd_fire    (rd_fire)
  );

  lws_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk        (clk),
    .addr       (addr),
    .wr_lane_en (wr_lane_en),
    .rd_fire    (rd_fire),
    .wdata      (din),
    .rdata      (dout)
  );

  lws_outdrv u_outdrv (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc      (cyc),
    .rd_fire  (rd_fire),
    .oe_n     (oe_n),
    .rd_valid (rd_valid),
    .dout_en  (dout_en)
  );

endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             we_n,
  input logic             oe_n,
  input logic [LANES-1:0] lane_sel_n,
  input logic [LANES-1:0] wr_lane_en,
  input logic             dout_en
);

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  AST_OE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en); // R5

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |-> !dout_en); // R6

  AST_DESEL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (wr_lane_en == '0)); // R7

  AST_DESEL_NEXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_en); // R7

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_lane_en) != 0) |-> (!cs_n && !we_n)); // R1

  AST_UNSEL_LANE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lane_en & lane_sel_n) == '0); // R2

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(!cs_n && we_n) && !oe_n && !(!cs_n && !we_n)) |-> dout_en); // R4

  always @(negedge clk) begin
    if (!rst_n || !started) begin
      AST_RESET_QUIET: assert (!dout_en); // R9
    end
  end

endmodule

bind lane_write_store lws_checker #(.LANES(LANES)) u_lws_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .we_n       (we_n),
  .oe_n       (oe_n),
  .lane_sel_n (lane_sel_n),
  .wr_lane_en (wr_lane_en),
  .dout_en    (dout_en)
);

// File: tb/test_lane_write_store.sv
module test_lane_write_store;

  localparam int ADDR_W = 4;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int W      = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              cs_n = 1'b1;
  logic              we_n = 1'b1;
  logic [LANES-1:0]  lane_sel_n = '1;
  logic              oe_n = 1'b1;
  logic [W-1:0]      din = '0;
  logic [W-1:0]      dout;
  logic              dout_en;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model [DEPTH];

  always #5 clk = ~clk;

  lane_write_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_lane_write_store (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
    .lane_sel_n(lane_sel_n), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pattern(input int a, input int s);
    logic [63:0] v;
    v = (64'(a) * 64'd2654435761) ^ (64'(s) * 64'd40503) ^ 64'h5_A5C3_96E1;
    return v[W-1:0];
  endfunction

  // Merge new lanes into an old word, lane i at bits [9i+8:9i].
  function automatic logic [W-1:0] merge(input logic [W-1:0] old_w, input logic [W-1:0] new_w,
                                         input logic [LANES-1:0] sel_n);
    logic [W-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (!sel_n[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  task automatic go_idle();
    cs_n = 1'b1; we_n = 1'b1; lane_sel_n = '1; oe_n = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [W-1:0] d, input logic [LANES-1:0] sel_n);
    addr = ADDR_W'(a); cs_n = 1'b0; we_n = 1'b0; lane_sel_n = sel_n; din = d; oe_n = 1'b0;
    #1;
    check(dout_en == 1'b0, sel_n == '1 ? "R8 no drive on empty write" : "R6 no drive on write",
          W'(dout_en), '0);
    @(posedge clk); #1;
    model[a] = merge(model[a], d, sel_n);
    go_idle();
    #1;
    check(dout_en == 1'b0, "R6 no drive after write", W'(dout_en), '0);
  endtask

  task automatic do_read(input int a, input string req);
    addr = ADDR_W'(a); cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); #1;
    go_idle();
    #1;
    check(dout_en == 1'b1, "R4 drive after read", W'(dout_en), W'(1));
    check(dout == model[a], req, dout, model[a]);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(dout_en == 1'b0, "R9 reset quiet", W'(dout_en), '0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(dout_en == 1'b0, "R9 quiet after release", W'(dout_en), '0);

    // Full-word fill, then read back every word.
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = '0;
      do_write(a, pattern(a, 0), '0);
    end
    for (int a = 0; a < DEPTH; a++) do_read(a, "R3 full word readback");

    // Every lane mask at every address, each followed by a readback.
    for (int a = 0; a < DEPTH; a++)
      for (int m = 0; m < (1 << LANES); m++) begin
        do_write(a, pattern(a, m + 1), LANES'(m));
        do_read(a, m == (1 << LANES) - 1 ? "R8 empty write keeps word" : "R1 R2 masked write");
      end

    // Output enable high blocks the drive of a completed read.
    addr = 3; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    @(posedge clk); #1;
    cs_n = 1'b1; we_n = 1'b1; #1;
    check(dout_en == 1'b0, "R5 oe high blocks", W'(dout_en), '0);
    oe_n = 1'b0; #1;
    check(dout_en == 1'b1, "R5 oe low restores", W'(dout_en), W'(1));

    // Read then an immediate write with oe low: write phase wins.
    addr = 5; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); #1;
    we_n = 1'b0; lane_sel_n = '0; din = pattern(5, 99); #1;
    check(dout_en == 1'b0, "R6 write overrides oe", W'(dout_en), '0);
    @(posedge clk); #1;
    model[5] = pattern(5, 99);
    go_idle();
    do_read(5, "R6 write after read stored");

    // Deselected cycle with write controls active stores nothing.
    addr = 7; cs_n = 1'b1; we_n = 1'b0; lane_sel_n = '0; din = ~model[7]; oe_n = 1'b0;
    @(posedge clk); #1;
    go_idle(); #1;
    check(dout_en == 1'b0, "R7 off after deselect", W'(dout_en), '0);
    do_read(7, "R7 deselect writes nothing");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule